// File: doc/BRIEF.md
# Fetch Command Requester

This block is the requesting end of a byte-wide fetch link. A one-cycle start pulse carries a byte address and a transfer length. The block turns them into a short command and sends it one byte per write strobe on the transmit side. It then pulls back exactly the requested number of data bytes from the receive side, with one read strobe per byte.

Every byte it receives is passed on, one cycle later, on a valid/data pair. A one-cycle done pulse closes the transfer. A busy output covers the whole exchange, and a new start is only taken once the block is idle again.

Flow control rests on one contract with the far side. The transmit full flag and the receive empty flag may fall at any time, but they rise only in the cycle after one of this block's own strobes. So the block can check the flag in the current cycle and strobe on consecutive cycles for as long as the flag stays low.

Top module: `fetch_cmd_requester`

## Requirements
- R1: A start pulse seen while idle makes busy high from the next cycle on. Busy stays high until the transfer ends and is already low in the cycle where done is high.
- R2: A transmit write strobe is only ever issued in a cycle where the full flag is low. Each strobe carries one byte, and strobes may come on back-to-back cycles.
- R3: The command has (ADDR_W+LEN_W)/8 bytes, one per write strobe. The address bytes come first, most significant byte first, and the length bytes follow, most significant byte first. No other transmit writes occur in a transfer.
- R4: While the full flag is high the command sequence stalls. When the flag falls it resumes with the byte it was holding, so the order is unchanged.
- R5: A receive read strobe is only issued while the empty flag is low, and never before the last command byte has been written.
- R6: Exactly LEN read strobes are issued per transfer. The byte present on the receive data input at each read appears on rsp_data with rsp_valid high in the following cycle.
- R7: Done is a one-cycle pulse per transfer. For LEN > 0 it is high in the same cycle as the last rsp_valid. For LEN = 0 no read is made, and done is high in the cycle after the last command write.
- R8: A start pulse while busy is ignored. The address and length captured at the accepted start are kept, and no second transfer follows.
- R9: After reset busy, done, rsp_valid, the transmit write strobe and the receive read strobe are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a transfer |
| addr_i | input | ADDR_W | Start byte address, captured at start |
| len_i | input | LEN_W | Number of response bytes, captured at start |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| tx_full_i | input | 1 | Transmit buffer full flag from the far side |
| tx_write_o | output | 1 | Transmit write strobe |
| tx_data_o | output | 8 | Command byte presented with the write strobe |
| rx_empty_i | input | 1 | Receive buffer empty flag from the far side |
| rx_read_o | output | 1 | Receive read acknowledge strobe |
| rx_data_i | input | 8 | Receive byte offered by the far side |
| rsp_valid_o | output | 1 | Forwarded response byte is valid |
| rsp_data_o | output | 8 | Forwarded response byte |

## Verification
The bench builds the block with ADDR_W = 16 and LEN_W = 8, which gives a three-byte command.

With that small setting it can sweep every length from 0 to 12 against three transmit buffer depths and three receive refill gaps. This covers back-to-back strobes, stalls on a full buffer after every command byte, a starved receive side, data that is ready before the command has finished, and the zero-length case.

A long transfer with start held high in mid-flight exercises the ignore rule.

// File: rtl/fcr_pkg.sv
package fcr_pkg;

    typedef enum logic [1:0] {
        FCR_IDLE = 2'd0,
        FCR_CMD  = 2'd1,
        FCR_RSP  = 2'd2
    } fcr_state_e;

endpackage

// File: rtl/fcr_cmd_tx.sv
module fcr_cmd_tx #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LEN_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              tx_full_i,
    output logic              tx_write_o,
    output logic [7:0]        tx_data_o,
    output logic              last_o
);

    localparam int unsigned CMD_W  = ADDR_W + LEN_W;
    localparam int unsigned NBYTES = CMD_W / 8;
    localparam int unsigned CNT_W  = $clog2(NBYTES + 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] left;
        logic [CMD_W-1:0] shreg;
    } tx_reg_t;

    tx_reg_t q, d;
    logic    wr;

    always_comb begin
        d  = q;
        wr = q.active && !tx_full_i;
        if (load_i) begin
            d.active = 1'b1;
            d.left   = CNT_W'(NBYTES);
            d.shreg  = {addr_i, len_i};
        end else if (wr) begin
            d.shreg = q.shreg << 8;
            d.left  = q.left - 1'b1;
            if (q.left == CNT_W'(1)) begin
                d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign tx_write_o = wr;
    assign tx_data_o  = q.shreg[CMD_W-1 -: 8];
    assign last_o     = wr && (q.left == CNT_W'(1));

    // R3: a new command is only loaded once the previous one is fully sent
    a_r3_load_when_idle : assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |-> !q.active);

    // R4: a stalled byte stays on the data lines until it is written
    a_r4_stall_holds_byte : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.active && !tx_write_o && !load_i) |=> (tx_data_o == $past(tx_data_o)));

    // R3: the byte counter never runs past the command size
    a_r3_count_bound : assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.left <= CNT_W'(NBYTES));

endmodule

// File: rtl/fcr_rsp_rx.sv
module fcr_rsp_rx #(
    parameter int unsigned LEN_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             rx_empty_i,
    input  logic [7:0]       rx_data_i,
    output logic             rx_read_o,
    output logic             rsp_valid_o,
    output logic [7:0]       rsp_data_o,
    output logic             last_o
);

    typedef struct packed {
        logic             active;
        logic [LEN_W-1:0] left;
        logic             valid;
        logic [7:0]       data;
    } rx_reg_t;

    rx_reg_t q, d;
    logic    rd;

    always_comb begin
        d       = q;
        rd      = q.active && !rx_empty_i;
        d.valid = rd;
        if (rd) begin
            d.data = rx_data_i;
        end
        if (load_i) begin
            d.active = 1'b1;
            d.left   = len_i;
        end else if (rd) begin
            d.left = q.left - 1'b1;
            if (q.left == LEN_W'(1)) begin
                d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rx_read_o   = rd;
    assign rsp_valid_o = q.valid;
    assign rsp_data_o  = q.data;
    assign last_o      = rd && (q.left == LEN_W'(1));

    // R6: every read acknowledge yields a forwarded byte one cycle later
    a_r6_valid_after_read : assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_read_o |=> rsp_valid_o);

    // R6: forwarded data equals the byte present at the read
    a_r6_data_from_read : assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_read_o |=> (rsp_data_o == $past(rx_data_i)));

    // R7: a zero-length transfer never starts the collector
    a_r7_load_nonzero : assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |-> (len_i != '0));

endmodule

// File: rtl/fetch_cmd_requester.sv
module fetch_cmd_requester
    import fcr_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LEN_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              busy_o,
    output logic              done_o,
    input  logic              tx_full_i,
    output logic              tx_write_o,
    output logic [7:0]        tx_data_o,
    input  logic              rx_empty_i,
    output logic              rx_read_o,
    input  logic [7:0]        rx_data_i,
    output logic              rsp_valid_o,
    output logic [7:0]        rsp_data_o
);

    typedef struct packed {
        fcr_state_e       state;
        logic [LEN_W-1:0] len;
        logic             done;
    } top_reg_t;

    top_reg_t q, d;
    logic     tx_load, tx_last;
    logic     rx_load, rx_last;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        tx_load = 1'b0;
        rx_load = 1'b0;
        unique case (q.state)
            FCR_IDLE: begin
                if (start_i) begin
                    tx_load = 1'b1;
                    d.len   = len_i;
                    d.state = FCR_CMD;
                end
            end
            FCR_CMD: begin
                if (tx_last) begin
                    if (q.len == '0) begin
                        d.state = FCR_IDLE;
                        d.done  = 1'b1;
                    end else begin
                        rx_load = 1'b1;
                        d.state = FCR_RSP;
                    end
                end
            end
            FCR_RSP: begin
                if (rx_last) begin
                    d.state = FCR_IDLE;
                    d.done  = 1'b1;
                end
            end
            default: d.state = FCR_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '{state: FCR_IDLE, len: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    fcr_cmd_tx #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) i_cmd_tx (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tx_load),
        .addr_i     (addr_i),
        .len_i      (len_i),
        .tx_full_i  (tx_full_i),
        .tx_write_o (tx_write_o),
        .tx_data_o  (tx_data_o),
        .last_o     (tx_last)
    );

    fcr_rsp_rx #(
        .LEN_W (LEN_W)
    ) i_rsp_rx (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (rx_load),
        .len_i       (q.len),
        .rx_empty_i  (rx_empty_i),
        .rx_data_i   (rx_data_i),
        .rx_read_o   (rx_read_o),
        .rsp_valid_o (rsp_valid_o),
        .rsp_data_o  (rsp_data_o),
        .last_o      (rx_last)
    );

    assign busy_o = (q.state != FCR_IDLE);
    assign done_o = q.done;

    // R2: no transmit write lands on a full buffer
    a_r2_write_not_full : assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_write_o |-> !tx_full_i);

    // R5: no receive read on an empty buffer
    a_r5_read_not_empty : assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_read_o |-> !rx_empty_i);

    // R5: no read while the command is still going out
    a_r5_no_read_in_cmd : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state != FCR_RSP) |-> !rx_read_o);

    // R7: done lasts a single cycle
    a_r7_done_pulse : assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R1: busy has dropped when done shows
    a_r1_done_not_busy : assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    // R8: a start while busy leaves the captured length untouched
    a_r8_start_ignored : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i) |=> (q.len == $past(q.len)));

    // R2/R3: strobes only while busy
    a_r3_write_only_busy : assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_write_o |-> busy_o);

endmodule

// File: tb/test_fetch_cmd_requester.sv
module test_fetch_cmd_requester;

    localparam int unsigned AW = 16;
    localparam int unsigned LW = 8;
    localparam int NCMD = (AW + LW) / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] a_in = '0;
    logic [LW-1:0] l_in = '0;
    logic          busy, done;
    logic          tx_full = 1'b0;
    logic          tx_write;
    logic [7:0]    tx_data;
    logic          rx_empty = 1'b1;
    logic          rx_read;
    logic [7:0]    rx_data = '0;
    logic          rsp_valid;
    logic [7:0]    rsp_data;

    always #4 clk = ~clk;

    fetch_cmd_requester #(.ADDR_W(AW), .LEN_W(LW)) i_fetch_cmd_requester (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(a_in), .len_i(l_in),
        .busy_o(busy), .done_o(done),
        .tx_full_i(tx_full), .tx_write_o(tx_write), .tx_data_o(tx_data),
        .rx_empty_i(rx_empty), .rx_read_o(rx_read), .rx_data_i(rx_data),
        .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data)
    );

    int checks = 0;
    int errors = 0;

    // far-side model state
    int cap = 1, rgap = 0;
    logic [AW-1:0] cur_addr = '0;
    int cur_len = 0;
    int tcnt = 0, ttick = 0, tx_n = 0;
    logic [7:0] tx_log [0:7];
    int rcnt = 0, rsup = 0, rcons = 0, rtick = 0;
    logic pend_wr = 1'b0, pend_rd = 1'b0;
    logic [7:0] pend_d = '0;
    int rsp_n = 0, done_n = 0, data_bad = 0;
    int viol_wr = 0, viol_rd = 0, viol_early = 0, viol_busy = 0;
    int cyc = 0, last_wr_cyc = 0, last_val_cyc = 0, done_cyc = 0;
    bit model_on = 1'b0;

    function automatic logic [7:0] exp_rsp(logic [AW-1:0] a, int k);
        return (a[7:0] + 8'(k * 7)) ^ 8'h5A;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // far-side model: flags rise only in response to strobes
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (model_on) begin
                ttick++;
                if ((ttick % 2) == 0 && tcnt > 0) tcnt--;
                if (pend_wr) begin
                    if (tx_n < 8) tx_log[tx_n] = pend_d;
                    tx_n++;
                    tcnt++;
                end
                tx_full = (tcnt >= cap);
                if (pend_rd) begin
                    rcnt--;
                    rcons++;
                end
                rtick++;
                if ((rtick % (rgap + 1)) == 0 && rcnt < 2 && rsup < cur_len) begin
                    rcnt++;
                    rsup++;
                end
                rx_empty = (rcnt == 0);
                rx_data  = exp_rsp(cur_addr, rcons);
            end
            #1;
            pend_wr = tx_write;
            pend_d  = tx_data;
            pend_rd = rx_read;
            if (tx_write) last_wr_cyc = cyc;
            if (tx_write && tx_full) viol_wr++;
            if (rx_read && rx_empty) viol_rd++;
            if (rx_read && tx_n < NCMD) viol_early++;
            if (rsp_valid) begin
                if (rsp_data != exp_rsp(cur_addr, rsp_n)) data_bad++;
                rsp_n++;
                last_val_cyc = cyc;
            end
            if (done) begin
                done_n++;
                done_cyc = cyc;
                if (busy) viol_busy++;
            end
        end
    end

    task automatic run_xfer(logic [AW-1:0] addr, int len, int cap_i, int gap_i, bit poke);
        logic [7:0] exp_cmd [0:NCMD-1];
        int t;
        exp_cmd[0] = addr[15:8];
        exp_cmd[1] = addr[7:0];
        exp_cmd[2] = 8'(len);
        @(negedge clk); #2;
        cap = cap_i; rgap = gap_i; cur_addr = addr; cur_len = len;
        tcnt = 0; ttick = 0; tx_n = 0; rcnt = 0; rsup = 0; rcons = 0; rtick = 0;
        rsp_n = 0; done_n = 0; data_bad = 0;
        viol_wr = 0; viol_rd = 0; viol_early = 0; viol_busy = 0;
        model_on = 1'b1;
        start = 1'b1; a_in = addr; l_in = LW'(len);
        @(negedge clk); #2;
        chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
        start = 1'b0; a_in = ~addr; l_in = LW'(len + 5);
        if (poke) begin
            repeat (2) @(negedge clk);
            #2;
            start = 1'b1; a_in = addr ^ 16'h3C3C; l_in = 8'd2;
            repeat (3) @(negedge clk);
            #2;
            start = 1'b0;
        end
        t = 0;
        while (done_n == 0 && t < 2000) begin
            @(negedge clk); #2;
            t++;
        end
        repeat (4) @(negedge clk);
        #2;
        chk(done_n == 1, "R7 single done", done_n, 1);
        chk(tx_n == NCMD, "R3 command length", tx_n, NCMD);
        for (int i = 0; i < NCMD; i++) begin
            chk(tx_log[i] == exp_cmd[i], "R3 command byte order", tx_log[i], exp_cmd[i]);
        end
        chk(rsp_n == len, "R6 response count", rsp_n, len);
        chk(data_bad == 0, "R6 response data", data_bad, 0);
        chk(viol_wr == 0, "R2 R4 write while full", viol_wr, 0);
        chk(viol_rd == 0, "R5 read while empty", viol_rd, 0);
        chk(viol_early == 0, "R5 read before command end", viol_early, 0);
        chk(viol_busy == 0, "R1 busy with done", viol_busy, 0);
        chk(busy == 1'b0, "R1 idle after transfer", int'(busy), 0);
        if (len == 0)
            chk(done_cyc == last_wr_cyc + 1, "R7 zero length done timing", done_cyc, last_wr_cyc + 1);
        else
            chk(done_cyc == last_val_cyc, "R7 done with last byte", done_cyc, last_val_cyc);
        if (poke)
            chk(done_n == 1 && tx_n == NCMD, "R8 start while busy ignored", tx_n, NCMD);
        model_on = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        // R9 reset state
        chk(busy == 1'b0, "R9 busy after reset", int'(busy), 0);
        chk(done == 1'b0, "R9 done after reset", int'(done), 0);
        chk(rsp_valid == 1'b0, "R9 rsp_valid after reset", int'(rsp_valid), 0);
        chk(tx_write == 1'b0, "R9 tx_write after reset", int'(tx_write), 0);
        chk(rx_read == 1'b0, "R9 rx_read after reset", int'(rx_read), 0);
        for (int len = 0; len <= 12; len++) begin
            for (int c = 1; c <= 3; c++) begin
                for (int g = 0; g <= 2; g++) begin
                    run_xfer(16'(16'hA100 + len * 37 + c * 5 + g), len, c, g, 1'b0);
                end
            end
        end
        run_xfer(16'hBEEF, 10, 1, 2, 1'b1);
        run_xfer(16'h0102, 12, 3, 0, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule